// File: doc/BRIEF.md
# Absolute Indexed Address Sequencer

This block computes the effective address of an absolute-indexed memory operand in a small pipelined 8-bit processor. A one-cycle start pulse begins a run at the given opcode address. The block then places the opcode address, the next address and the one after that on the read port. It reads the low operand byte first and adds the index to it at once. It then reads the high operand byte, and finally reads the data at the effective address.

The index sum is formed while the high byte is still being fetched. When that sum carries, one fix-up cycle increments the high byte before the data read, so a run takes four or five cycles in total. During the data-read cycle a done strobe marks the effective address on the bus, and the byte read there is captured at the end of that cycle. A cycle counter shows the position of the current cycle in the run, so that the timing can be checked.

Top module: `abs_indexed_agu`

## Requirements
- R1: While reset is held, and just after it is released, done is 0, cycleCount is 0, effAddr is 0 and loadData is 0.
- R2: A start pulse accepted while idle makes the next cycle the opcode-fetch cycle. In that cycle memAddr equals the opAddr sampled with start, and cycleCount is 1.
- R3: The low operand byte is read in cycle 2 at opAddr+1, and the high byte is read in cycle 3 at opAddr+2. Both addresses wrap modulo 2^16.
- R4: When the low byte plus the index is below 256, done is high in cycle 4 and cycleCount reads 4.
- R5: When the low byte plus the index is 256 or more, one fix-up cycle is inserted. Done is then high in cycle 5 and cycleCount reads 5.
- R6: In the done cycle, effAddr and memAddr both equal {high + carry, (low + index) mod 256} taken modulo 2^16. The index is sampled at the end of cycle 2.
- R7: loadData takes memData at the rising edge that ends the done cycle, and holds it until the next run.
- R8: A start pulse that arrives while a run is in progress is ignored, including one that arrives in the done cycle. The address result is unchanged, and the block is idle afterwards.
- R9: Done lasts exactly one cycle. In the cycle after it the block is idle with cycleCount 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (sampled while idle) |
| opAddr | input | 16 | Address of the opcode byte |
| index | input | 8 | Index register value |
| memData | input | 8 | Read data for memAddr |
| memAddr | output | 16 | Read address for the current cycle |
| effAddr | output | 16 | Effective address, valid while done |
| done | output | 1 | High in the data-read cycle |
| loadData | output | 8 | Byte captured at the effective address |
| cycleCount | output | 3 | Cycle position within the run, 0 when idle |

## Verification
Two functions can meet in the same cycle: the final data read, with its done strobe, and a new start request. The bench raises start during the done cycle of a run that needed the carry fix-up, and also during its low-byte cycle. It then checks that the loaded byte and the address match the first request. It also checks that the cycle after done shows an idle counter rather than a new opcode fetch. A separate vector combines the fix-up with a high byte of 0xFF, so that the increment and the 16-bit wrap also fall together.

// File: rtl/aix_pkg.sv
package aix_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_LOW, ST_HIGH, ST_FIX, ST_READ
  } seqState_t;

  typedef enum logic [1:0] {
    SEL_PC, SEL_PC1, SEL_PC2, SEL_EFF
  } addrSel_t;

  typedef struct packed {
    logic     loadPc;
    logic     takeLow;
    logic     takeHigh;
    logic     incHigh;
    logic     takeData;
    addrSel_t addrSel;
  } dpCtrl_t;
endpackage

// File: rtl/aix_ctrl.sv
module aix_ctrl
  import aix_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             carry,
  output dpCtrl_t          ctrl,
  output logic             done,
  output logic [CNT_W-1:0] cycleCount
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_OPC;
      ST_OPC:  stateNext = ST_LOW;
      ST_LOW:  stateNext = ST_HIGH;
      ST_HIGH: stateNext = carry ? ST_FIX : ST_READ;
      ST_FIX:  stateNext = ST_READ;
      ST_READ: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctrl          = '0;
    ctrl.loadPc   = (state == ST_IDLE) && start;
    ctrl.takeLow  = (state == ST_LOW);
    ctrl.takeHigh = (state == ST_HIGH);
    ctrl.incHigh  = (state == ST_FIX);
    ctrl.takeData = (state == ST_READ);
    unique case (state)
      ST_LOW:         ctrl.addrSel = SEL_PC1;
      ST_HIGH:        ctrl.addrSel = SEL_PC2;
      ST_FIX, ST_READ: ctrl.addrSel = SEL_EFF;
      default:        ctrl.addrSel = SEL_PC;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cycleCount <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE)      cycleCount <= start ? CNT_W'(1) : '0;
      else if (state == ST_READ) cycleCount <= '0;
      else                       cycleCount <= cycleCount + CNT_W'(1);
    end
  end

  assign done = (state == ST_READ);

  AST_CYCLES_MATCH_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycleCount == (carry ? CNT_W'(5) : CNT_W'(4))));      // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && cycleCount == '0));                           // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && start) |=> (cycleCount != CNT_W'(1)));      // R8
endmodule

// File: rtl/aix_datapath.sv
module aix_datapath
  import aix_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int DATA_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [DATA_W-1:0] loadData,
  output logic              carry
);
  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] lowReg;
  logic [DATA_W-1:0] hiReg;
  logic [DATA_W:0]   lowSum;

  assign lowSum = {1'b0, memData} + {1'b0, index};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg    <= '0;
      lowReg   <= '0;
      hiReg    <= '0;
      carry    <= 1'b0;
      loadData <= '0;
    end else begin
      if (ctrl.loadPc) pcReg <= opAddr;
      if (ctrl.takeLow) begin
        lowReg <= lowSum[DATA_W-1:0];
        carry  <= lowSum[DATA_W];
      end
      if (ctrl.takeHigh)      hiReg <= memData;
      else if (ctrl.incHigh)  hiReg <= hiReg + DATA_W'(1);
      if (ctrl.takeData) loadData <= memData;
    end
  end

  assign effAddr = {hiReg, lowReg};

  always_comb begin
    unique case (ctrl.addrSel)
      SEL_PC1: memAddr = pcReg + ADDR_W'(1);
      SEL_PC2: memAddr = pcReg + ADDR_W'(2);
      SEL_EFF: memAddr = effAddr;
      default: memAddr = pcReg;
    endcase
  end

  AST_OPERAND_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.addrSel == SEL_PC2) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));  // R3
  AST_HIGH_INCREMENT: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.incHigh |=> (hiReg == $past(hiReg) + DATA_W'(1)));                   // R5
endmodule

// File: rtl/abs_indexed_agu.sv
module abs_indexed_agu
  import aix_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int DATA_W = ADDR_W / 2,
  localparam int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [DATA_W-1:0] index,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic              done,
  output logic [DATA_W-1:0] loadData,
  output logic [CNT_W-1:0]  cycleCount
);
  dpCtrl_t ctrl;
  logic    carry;

  aix_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .carry(carry),
    .ctrl(ctrl), .done(done), .cycleCount(cycleCount)
  );

  aix_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opAddr(opAddr), .index(index),
    .memData(memData), .memAddr(memAddr), .effAddr(effAddr),
    .loadData(loadData), .carry(carry)
  );

  AST_EFF_ON_BUS: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (memAddr == effAddr));                                   // R6
  AST_OPC_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    (cycleCount == CNT_W'(1)) |-> (memAddr == $past(opAddr)));        // R2
endmodule

// File: tb/tb_abs_indexed_agu.sv
`timescale 1ns/1ps
module tb_abs_indexed_agu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] opAddr = '0;
  logic [7:0]  index = '0;
  logic [7:0]  memData;
  logic [15:0] memAddr, effAddr;
  logic        done;
  logic [7:0]  loadData;
  logic [2:0]  cycleCount;

  logic [15:0] curPc = 16'h0;
  logic [7:0]  curLo = 8'h0, curHi = 8'h0;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  abs_indexed_agu dut (
    .clk(clk), .rstN(rstN), .start(start), .opAddr(opAddr), .index(index),
    .memData(memData), .memAddr(memAddr), .effAddr(effAddr), .done(done),
    .loadData(loadData), .cycleCount(cycleCount)
  );

  function automatic logic [7:0] pattern(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb begin
    if (memAddr == curPc + 16'd1)      memData = curLo;
    else if (memAddr == curPc + 16'd2) memData = curHi;
    else                               memData = pattern(memAddr);
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {pc, low, high, index, expected address, expected cycles}
  localparam logic [63:0] VEC [6] = '{
    {16'h1000, 8'h34, 8'h12, 8'h05, 16'h1239, 8'd4},
    {16'h2000, 8'hF0, 8'h12, 8'h20, 16'h1310, 8'd5},
    {16'h3000, 8'hFF, 8'hFF, 8'h01, 16'h0000, 8'd5},
    {16'hFFFE, 8'h80, 8'h40, 8'h7F, 16'h40FF, 8'd4},
    {16'h4000, 8'h00, 8'hAB, 8'h00, 16'hAB00, 8'd4},
    {16'h5000, 8'h01, 8'h77, 8'hFF, 16'h7800, 8'd5}
  };

  task automatic runVec(input logic [63:0] v, input bit poke);
    logic [15:0] pc, expEff;
    int expCyc, cyc;
    pc = v[63:48]; expEff = v[23:8]; expCyc = int'(v[7:0]);
    curPc = pc; curLo = v[47:40]; curHi = v[39:32];
    opAddr = pc; index = v[31:24];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (cyc < 8) begin
      if (cyc == 1) begin
        check(memAddr == pc, "R2 opcode address", memAddr, pc);
        check(cycleCount == 3'd1, "R2 count", cycleCount, 1);
      end
      if (cyc == 2) check(memAddr == pc + 16'd1, "R3 low address", memAddr, pc + 16'd1);
      if (cyc == 3) check(memAddr == pc + 16'd2, "R3 high address", memAddr, pc + 16'd2);
      if (poke && cyc == 2) begin start = 1'b1; opAddr = pc ^ 16'h0F0F; end
      if (poke && cyc == 3) begin start = 1'b0; opAddr = pc; end
      if (done) break;
      cyc++;
      @(negedge clk);
    end
    if (poke) start = 1'b1;  // R8: request during the done cycle
    check(cyc == expCyc, expCyc == 5 ? "R5 run length" : "R4 run length", cyc, expCyc);
    check(cycleCount == 3'(expCyc), "R4/R5 cycleCount", cycleCount, expCyc);
    check(effAddr == expEff, "R6 effAddr", effAddr, expEff);
    check(memAddr == expEff, "R6 memAddr", memAddr, expEff);
    @(negedge clk);
    start = 1'b0;
    check(loadData == pattern(expEff), "R7 loadData", loadData, pattern(expEff));
    check(!done && cycleCount == 3'd0, poke ? "R8 idle after ignored start" : "R9 idle",
          {done, cycleCount}, 0);
    @(negedge clk);
    check(loadData == pattern(expEff), "R7 loadData held", loadData, pattern(expEff));
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check(!done && cycleCount == 0 && effAddr == 0 && loadData == 0, "R1 in reset",
          {done, cycleCount, effAddr, loadData}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && cycleCount == 0, "R1 after release", {done, cycleCount}, 0);
    for (int i = 0; i < 6; i++) runVec(VEC[i], 1'b0);
    runVec(VEC[1], 1'b1);  // R8: starts in cycle 2 and in the done cycle
    runVec(VEC[2], 1'b1);  // R8 with carry and 16-bit wrap
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule